// File: doc/BRIEF.md
# Circular Trace Capture Memory

This block keeps a rolling history of core state. On every clock where recording is allowed, it stores one wide sample (four 64-bit lanes, 256 bits in all) in an entry memory and then advances a write position. When the position passes the last entry it goes back to entry 0 and flips a lap flag. Software can then tell the newest entry apart from stale ones. The write position is published as a 32-bit word, so a reader can find where the history ends.

Two readers share the one memory read path. The core reader is served on every cycle. The debug reader gets the path only in the cycle where it pulses a request, and its result lands in a separate held register two clocks later. Each reader names an entry and a lane with a byte-style address: bits [1:0] pick the 64-bit lane and the bits above them pick the entry. Setting the top bit of either reader's address stops recording, so the history can be examined without being overwritten.

Top module: `trace_log_buffer`

## Requirements
- R1: While reset is held, `wr_pos_o` reads as `1 << IDX_W` (write position 0), `wrap_o` is 0, and both read-data outputs are 0.
- R2: On each clock where recording is enabled and reset is low, the memory stores `sample_i` at the current write position. The position then advances by one, modulo `LOG_LENGTH`.
- R3: Recording is enabled only while bit 31 of `core_rd_addr_i` and bit 31 of `dbg_rd_addr_i` are both 0. While either bit is 1, the write position, the lap flag and every stored entry stay unchanged.
- R4: `wrap_o` inverts on exactly those enabled clocks where the write position moves from `LOG_LENGTH-1` to 0. It is otherwise steady.
- R5: The core reader returns lane `a[1:0]` of entry `a[IDX_W+1:2]`, where lane k is bits [64k+63:64k] of the stored sample. The result appears on `core_rd_data_o` at the third rising edge after the address is applied, while the address is held.
- R6: A one-cycle pulse on `dbg_rd_req_i` reads the entry and lane given by `dbg_rd_addr_i`, decoded the same way as in R5. The result is loaded into `dbg_rd_data_o` at the second rising edge after the edge that captured the pulse. `dbg_rd_data_o` changes at no other time.
- R7: In the cycle of a debug request, the memory index comes from the debug address. In the debug result cycle, `core_rd_data_o` keeps its previous value. With its address held, the core reader returns its own lane both before and after a debug read.
- R8: `wr_pos_o` carries the write position in bits [IDX_W-1:0] and a 1 in bit IDX_W. All bits above IDX_W are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_i | input | 256 | Core state sample recorded each enabled clock |
| core_rd_addr_i | input | 32 | Core reader address; bit 31 stops recording |
| core_rd_data_o | output | 64 | Core reader lane result |
| dbg_rd_addr_i | input | 32 | Debug reader address; bit 31 stops recording |
| dbg_rd_req_i | input | 1 | One-cycle debug read request pulse |
| dbg_rd_data_o | output | 64 | Held debug read result |
| wr_pos_o | output | 32 | Published write position word |
| wrap_o | output | 1 | Lap flag, flips on every wrap of the write position |

## Verification
The core reader and the debug reader meet in two cycles. In the request cycle both want the memory index. In the result cycle both want the lane steering. To provoke this, the bench holds the core address on one entry and lane and pulses a debug request for a different entry and lane. It then samples both outputs right after the debug result edge. The debug register must hold the debug lane, and the core output must still hold the core lane rather than the debug one. Recording is stopped throughout, so the expected contents come from a model memory that the bench fills from the samples it drove.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned SLICE_W = 64;
  localparam int unsigned SLICES  = 4;
  localparam int unsigned ENTRY_W = SLICE_W * SLICES;
  localparam int unsigned SEL_W   = $clog2(SLICES);
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned STOP_BIT = ADDR_W - 1;

  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [SLICE_W-1:0] slice_t;
  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [SEL_W-1:0]   sel_t;

  // lane k of an entry occupies bits [k*SLICE_W +: SLICE_W]
  function automatic slice_t pick_slice(input entry_t e, input sel_t sel);
    return e[sel*SLICE_W +: SLICE_W];
  endfunction

  // entry number sits directly above the lane select bits
  function automatic addr_t entry_index(input addr_t a, input int unsigned iw);
    addr_t mask;
    mask = (addr_t'(1) << iw) - addr_t'(1);
    return (a >> SEL_W) & mask;
  endfunction

  function automatic logic stop_req(input addr_t a);
    return a[STOP_BIT];
  endfunction

  // published position: pointer below a marker bit at position iw
  function automatic addr_t pos_word(input addr_t ptr, input int unsigned iw);
    return (addr_t'(1) << iw) | ptr;
  endfunction
endpackage

// File: rtl/tlb_wr_ctrl.sv
module tlb_wr_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             wrap_o,
  output logic             at_last_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr_q;
  logic             wrap_q;

  assign at_last_o = (ptr_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else if (adv_i) begin
      ptr_q <= at_last_o ? '0 : ptr_q + 1'b1;
      if (at_last_o) wrap_q <= ~wrap_q;
    end
  end

  assign ptr_o  = ptr_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/tlb_entry_ram.sv
module tlb_entry_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/tlb_rd_path.sv
module tlb_rd_path
  import tlb_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  addr_t            core_addr_i,
  input  addr_t            dbg_addr_i,
  input  logic             dbg_req_i,
  input  entry_t           ram_q_i,
  output logic [IDX_W-1:0] ram_idx_o,
  output slice_t           core_data_o,
  output slice_t           dbg_data_o,
  output logic             dbg_busy_o,
  output logic             dbg_done_o
);
  logic [IDX_W-1:0] idx_q;
  logic             busy_q, done_q;
  slice_t           core_q, dbg_q;
  logic [IDX_W-1:0] core_idx, dbg_idx;

  assign core_idx = IDX_W'(entry_index(core_addr_i, IDX_W));
  assign dbg_idx  = IDX_W'(entry_index(dbg_addr_i, IDX_W));

  // index stage: debug request owns the read path for one cycle
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= dbg_req_i ? dbg_idx : core_idx;
      busy_q <= dbg_req_i;
      done_q <= busy_q;
    end
  end

  // steering stage: the result cycle feeds the debug register only
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      core_q <= '0;
      dbg_q  <= '0;
    end else if (done_q) begin
      dbg_q <= pick_slice(ram_q_i, dbg_addr_i[SEL_W-1:0]);
    end else begin
      core_q <= pick_slice(ram_q_i, core_addr_i[SEL_W-1:0]);
    end
  end

  assign ram_idx_o   = idx_q;
  assign core_data_o = core_q;
  assign dbg_data_o  = dbg_q;
  assign dbg_busy_o  = busy_q;
  assign dbg_done_o  = done_q;
endmodule

// File: rtl/trace_log_buffer.sv
module trace_log_buffer
  import tlb_pkg::*;
#(
  parameter int unsigned LOG_LENGTH = 16,
  localparam int unsigned IDX_W = $clog2(LOG_LENGTH)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [ENTRY_W-1:0]  sample_i,
  input  logic [ADDR_W-1:0]   core_rd_addr_i,
  output logic [SLICE_W-1:0]  core_rd_data_o,
  input  logic [ADDR_W-1:0]   dbg_rd_addr_i,
  input  logic                dbg_rd_req_i,
  output logic [SLICE_W-1:0]  dbg_rd_data_o,
  output logic [ADDR_W-1:0]   wr_pos_o,
  output logic                wrap_o
);
  // named internal events
  logic             wr_en;
  logic             wr_at_last;
  logic [IDX_W-1:0] wr_ptr;
  logic [IDX_W-1:0] ram_idx;
  entry_t           ram_q;
  logic             dbg_busy;
  logic             dbg_done;

  assign wr_en = !rst_i && !stop_req(core_rd_addr_i) && !stop_req(dbg_rd_addr_i);

  tlb_wr_ctrl #(.DEPTH(LOG_LENGTH)) u_wr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .adv_i     (wr_en),
    .ptr_o     (wr_ptr),
    .wrap_o    (wrap_o),
    .at_last_o (wr_at_last)
  );

  tlb_entry_ram #(.DEPTH(LOG_LENGTH), .WIDTH(ENTRY_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_ptr),
    .wdata_i (sample_i),
    .raddr_i (ram_idx),
    .rdata_o (ram_q)
  );

  tlb_rd_path #(.IDX_W(IDX_W)) u_rd (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .core_addr_i (core_rd_addr_i),
    .dbg_addr_i  (dbg_rd_addr_i),
    .dbg_req_i   (dbg_rd_req_i),
    .ram_q_i     (ram_q),
    .ram_idx_o   (ram_idx),
    .core_data_o (core_rd_data_o),
    .dbg_data_o  (dbg_rd_data_o),
    .dbg_busy_o  (dbg_busy),
    .dbg_done_o  (dbg_done)
  );

  assign wr_pos_o = pos_word(addr_t'(wr_ptr), IDX_W);
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
  import tlb_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               core_stop,
  input logic               dbg_stop,
  input logic               dbg_req,
  input logic               dbg_done,
  input logic               at_last,
  input logic [ADDR_W-1:0]  wr_pos,
  input logic               wrap,
  input logic [SLICE_W-1:0] core_data,
  input logic [SLICE_W-1:0] dbg_data
);
  logic rec;
  assign rec = !core_stop && !dbg_stop;

  // R2
  pos_advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rec |=> wr_pos[IDX_W-1:0] == $past(wr_pos[IDX_W-1:0]) + 1'b1);

  // R3
  pos_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rec |=> ($stable(wr_pos) && $stable(wrap)));

  // R4
  wrap_flip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rec && at_last) |=> wrap != $past(wrap));

  // R4
  wrap_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rec && !at_last) |=> $stable(wrap));

  // R6
  dbg_latency_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    dbg_req |-> ##2 dbg_done);

  // R6
  dbg_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !dbg_done |=> $stable(dbg_data));

  // R7
  core_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    dbg_done |=> $stable(core_data));
endmodule

bind trace_log_buffer tlb_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .core_stop (core_rd_addr_i[tlb_pkg::STOP_BIT]),
  .dbg_stop  (dbg_rd_addr_i[tlb_pkg::STOP_BIT]),
  .dbg_req   (dbg_rd_req_i),
  .dbg_done  (dbg_done),
  .at_last   (wr_at_last),
  .wr_pos    (wr_pos_o),
  .wrap      (wrap_o),
  .core_data (core_rd_data_o),
  .dbg_data  (dbg_rd_data_o)
);

// File: tb/trace_log_buffer_tb.sv
`timescale 1ns/1ps
module trace_log_buffer_tb;
  localparam int LEN = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] sample = '0;
  logic [31:0]  core_addr = 32'h8000_0000;
  logic [31:0]  dbg_addr = 32'h0;
  logic         dbg_req = 1'b0;
  logic [63:0]  core_data, dbg_data;
  logic [31:0]  wr_pos;
  logic         wrap;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  trace_log_buffer #(.LOG_LENGTH(LEN)) u_dut (
    .clk_i(clk), .rst_i(rst), .sample_i(sample),
    .core_rd_addr_i(core_addr), .core_rd_data_o(core_data),
    .dbg_rd_addr_i(dbg_addr), .dbg_rd_req_i(dbg_req),
    .dbg_rd_data_o(dbg_data), .wr_pos_o(wr_pos), .wrap_o(wrap)
  );

  // lane k of sample c: marker, lane number, sample number
  function automatic logic [255:0] gen(input int c);
    logic [255:0] r;
    for (int k = 0; k < 4; k++) r[k*64 +: 64] = {16'hA5C3, 16'(k), 32'(c)};
    return r;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sample <= gen(cyc + 1);
  end

  // requirement model: recording happens when no stop bit is set
  logic [255:0] m_mem [LEN];
  logic [3:0]   m_ptr = '0;
  logic         m_wrap = 1'b0;
  always @(posedge clk) begin
    if (rst) begin
      m_ptr = '0; m_wrap = 1'b0;
    end else if (!core_addr[31] && !dbg_addr[31]) begin
      m_mem[m_ptr] = sample;
      if (m_ptr == 4'(LEN - 1)) m_wrap = ~m_wrap;
      m_ptr = m_ptr + 1'b1;
    end
  end

  function automatic logic [63:0] exp_lane(input logic [3:0] i, input logic [1:0] s);
    return m_mem[i][s*64 +: 64];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0] ci; logic [1:0] cs; logic [3:0] di; logic [1:0] ds;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{4'd0,  2'd0, 4'd15, 2'd3},
    '{4'd15, 2'd3, 4'd0,  2'd0},
    '{4'd3,  2'd1, 4'd4,  2'd2},
    '{4'd4,  2'd2, 4'd3,  2'd1},
    '{4'd7,  2'd0, 4'd7,  2'd3},
    '{4'd9,  2'd3, 4'd2,  2'd0},
    '{4'd1,  2'd2, 4'd14, 2'd1},
    '{4'd12, 2'd1, 4'd5,  2'd2}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1 pos", 64'(wr_pos), 64'h10);
    chk("R1 wrap", 64'(wrap), 64'h0);
    chk("R1 core", core_data, 64'h0);
    chk("R1 dbg", dbg_data, 64'h0);
    rst = 1'b0;
    step(2);
    chk("R3 stopped after reset", 64'(wr_pos), 64'h10);

    core_addr = 32'h0;
    step(15);
    chk("R2 pos after 15", 64'(wr_pos), 64'h1F);
    chk("R4 no wrap yet", 64'(wrap), 64'h0);
    step(1);
    chk("R4 pos wraps to 0", 64'(wr_pos), 64'h10);
    chk("R4 wrap flips", 64'(wrap), 64'h1);
    step(4);
    chk("R8 pos word", 64'(wr_pos), 64'h14);

    core_addr = 32'h8000_0000;
    step(6);
    chk("R3 core stop holds pos", 64'(wr_pos), 64'h14);
    chk("R3 core stop holds wrap", 64'(wrap), 64'h1);

    foreach (VECS[v]) begin
      core_addr = 32'h8000_0000 | {26'd0, VECS[v].ci, VECS[v].cs};
      step(3);
      chk($sformatf("R5 core lane v%0d", v), core_data, exp_lane(VECS[v].ci, VECS[v].cs));
      dbg_addr = 32'h8000_0000 | {26'd0, VECS[v].di, VECS[v].ds};
      dbg_req = 1'b1;
      step(1);
      dbg_req = 1'b0;
      step(1);
      chk($sformatf("R6 dbg not early v%0d", v), dbg_data,
          (v == 0) ? 64'h0 : exp_lane(VECS[v-1].di, VECS[v-1].ds));
      step(1);
      chk($sformatf("R6 dbg lane v%0d", v), dbg_data, exp_lane(VECS[v].di, VECS[v].ds));
      chk($sformatf("R7 core held v%0d", v), core_data, exp_lane(VECS[v].ci, VECS[v].cs));
      step(3);
      chk($sformatf("R7 core after v%0d", v), core_data, exp_lane(VECS[v].ci, VECS[v].cs));
      chk($sformatf("R6 dbg held v%0d", v), dbg_data, exp_lane(VECS[v].di, VECS[v].ds));
    end
    chk("R3 pos after reads", 64'(wr_pos), 64'h14);

    core_addr = 32'h0;
    dbg_addr = 32'h8000_0000;
    step(5);
    chk("R3 dbg stop holds pos", 64'(wr_pos), 64'h14);
    dbg_addr = 32'h0;
    step(3);
    chk("R2 resume", 64'(wr_pos), 64'h17);
    chk("R4 wrap steady", 64'(wrap), 64'h1);

    core_addr = 32'h8000_0000 | 32'h16;
    dbg_addr = 32'h8000_0000 | 32'h13;
    dbg_req = 1'b1;
    step(1);
    dbg_req = 1'b0;
    step(4);
    chk("R2 fresh entry dbg", dbg_data, exp_lane(4'd4, 2'd3));
    chk("R2 fresh entry core", core_data, exp_lane(4'd5, 2'd2));
    chk("R8 final pos", 64'(wr_pos), 64'(32'h10 | 32'(m_ptr)));
    finish_run();
  end
endmodule